// File: doc/BRIEF.md
# PWM Output Steering and Polarity Stage

This block sits between the PWM waveform generator and the I/O pads. It takes a primary PWM waveform, its complement, a set of per-pin fixed waveforms for the modes that assign signals to pins directly, and the current waveform mode. From these and the per-pin configuration (output enable, steering enable and polarity) it produces, for each of up to six pins, a drive level and an ownership flag. When the ownership flag is low, the pin goes back to general-purpose I/O.

Steering and enable are separate controls. A pin that is enabled but not steered stays owned by the block and is held at the inactive PWM level, so general-purpose output cannot reach it. Steering applies only in the single-phase, complementary single-phase and three-phase six-step modes. In every other mode each enabled pin carries its own mode-assigned waveform and the steering bits have no effect. Polarity is the last step, so an inverted pin rests high when inactive. All outputs are registered, and all inputs are sampled on the same clock edge.

The block has no state machine. Its one piece of sequential state is the output register, which has two conditions: held in reset, or tracking the inputs. It enters tracking on the first clock edge after `rst_n` is released and returns to reset whenever `rst_n` goes low.

Top module: `pwm_out_steer`

## Requirements
- R1: While `rst_n` is low, and on the first sampled cycle after reset, `pin_own` and `pin_drv` are all zero.
- R2: A pin whose enable bit is 0 has `pin_own` = 0 and `pin_drv` = 0 one clock after it is sampled, whatever its polarity, steering and waveform inputs are.
- R3: A pin whose enable bit is 1 has `pin_own` = 1 one clock later.
- R4: In the steered modes (`wave_mode` 0, 1 or 2), a pin that is enabled but not steered drives its polarity bit, which is the inactive level.
- R5: In single-phase mode (`wave_mode` = 0), every pin that is both enabled and steered drives `wave_a` XOR its polarity bit. Several pins can carry the waveform in the same cycle.
- R6: In complementary single-phase mode (`wave_mode` = 1), an enabled and steered pin with an even index (0, 2, 4) drives `wave_a` XOR polarity, and one with an odd index drives `wave_b` XOR polarity.
- R7: In three-phase six-step mode (`wave_mode` = 2), every pin that is both enabled and steered drives `wave_a` XOR polarity. The steering pattern selects the commutation step.
- R8: For `wave_mode` codes 3 to 7, every enabled pin i drives `fixed_drv[i]` XOR polarity, and `pin_steer` has no effect.
- R9: Polarity is applied after the routing step: a polarity bit of 1 inverts the routed level of an owned pin.
- R10: Outputs change exactly one clock after their inputs are sampled, and all of a cycle's inputs, including the mode, take effect on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wave_mode | input | 3 | Waveform mode code |
| wave_a | input | 1 | Primary PWM waveform |
| wave_b | input | 1 | Complementary PWM waveform |
| fixed_drv | input | PINS | Per-pin waveforms for the modes without steering |
| pin_en | input | PINS | Per-pin output enable |
| pin_steer | input | PINS | Per-pin steering enable |
| pin_pol | input | PINS | Per-pin polarity, 1 = inverted |
| pin_drv | output | PINS | Registered pin drive level |
| pin_own | output | PINS | Registered ownership, 0 = pin released to general-purpose I/O |

## Verification
Two functions can act on the same pin in one cycle: release by the enable bit and inversion by the polarity bit. Separately, a change of mode and a change of steering can land on the same edge. The bench provokes the first case by clearing an enable bit in the same cycle that its polarity flips to 1. It judges the result correct when the pin shows as released and drives low, with no inverted rest level leaking through. It provokes the second case by leaving single-phase mode for a non-steered mode in the same cycle that the steering pattern changes. It judges the result correct when the very next sample already shows the fixed per-pin waveforms, with no trace of either steering pattern.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;

    typedef enum logic [2:0] {
        WM_SINGLE    = 3'd0,
        WM_COMP      = 3'd1,
        WM_SIXSTEP   = 3'd2,
        WM_PUSHPULL  = 3'd3,
        WM_HALFBR    = 3'd4,
        WM_FULLBR    = 3'd5,
        WM_VARFREQ   = 3'd6,
        WM_RESERVED  = 3'd7
    } wave_mode_e;

    typedef struct packed {
        logic steer_on;
        logic comp_on;
    } route_ctl_t;

endpackage

// File: rtl/pwm_mode_decode.sv
module pwm_mode_decode
    import pwm_steer_pkg::*;
(
    input  logic [2:0] wave_mode,
    output route_ctl_t ctl
);
    wave_mode_e mode_q;

    always_comb begin
        mode_q = wave_mode_e'(wave_mode);
        ctl    = '0;
        unique case (mode_q)
            WM_SINGLE:   ctl.steer_on = 1'b1;
            WM_COMP:     begin ctl.steer_on = 1'b1; ctl.comp_on = 1'b1; end
            WM_SIXSTEP:  ctl.steer_on = 1'b1;
            WM_PUSHPULL,
            WM_HALFBR,
            WM_FULLBR,
            WM_VARFREQ,
            WM_RESERVED: ctl = '0;
        endcase
    end
endmodule

// File: rtl/pwm_pin_route.sv
module pwm_pin_route
    import pwm_steer_pkg::*;
#(
    parameter int IDX = 0
) (
    input  route_ctl_t ctl,
    input  logic       wave_a,
    input  logic       wave_b,
    input  logic       fixed_lvl,
    input  logic       en,
    input  logic       steer,
    input  logic       pol,
    output logic       drv_nxt,
    output logic       own_nxt
);
    localparam bit ODD_PIN = (IDX % 2) == 1;

    logic steered_sig;
    logic routed;

    always_comb begin
        steered_sig = (ctl.comp_on && ODD_PIN) ? wave_b : wave_a;
        if (ctl.steer_on)
            routed = steer ? steered_sig : 1'b0;
        else
            routed = fixed_lvl;
        own_nxt = en;
        drv_nxt = en ? (routed ^ pol) : 1'b0;
    end
endmodule

// File: rtl/pwm_out_reg.sv
module pwm_out_reg #(
    parameter int PINS = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] drv_nxt,
    input  logic [PINS-1:0] own_nxt,
    output logic [PINS-1:0] drv_q,
    output logic [PINS-1:0] own_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_q <= '0;
            own_q <= '0;
        end else begin
            drv_q <= drv_nxt;
            own_q <= own_nxt;
        end
    end
endmodule

// File: rtl/pwm_out_steer.sv
module pwm_out_steer
    import pwm_steer_pkg::*;
#(
    parameter int PINS = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      wave_mode,
    input  logic            wave_a,
    input  logic            wave_b,
    input  logic [PINS-1:0] fixed_drv,
    input  logic [PINS-1:0] pin_en,
    input  logic [PINS-1:0] pin_steer,
    input  logic [PINS-1:0] pin_pol,
    output logic [PINS-1:0] pin_drv,
    output logic [PINS-1:0] pin_own
);
    route_ctl_t      ctl;
    logic [PINS-1:0] drv_nxt;
    logic [PINS-1:0] own_nxt;

    pwm_mode_decode u_dec (
        .wave_mode (wave_mode),
        .ctl       (ctl)
    );

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        pwm_pin_route #(.IDX(i)) u_route (
            .ctl       (ctl),
            .wave_a    (wave_a),
            .wave_b    (wave_b),
            .fixed_lvl (fixed_drv[i]),
            .en        (pin_en[i]),
            .steer     (pin_steer[i]),
            .pol       (pin_pol[i]),
            .drv_nxt   (drv_nxt[i]),
            .own_nxt   (own_nxt[i])
        );
    end

    pwm_out_reg #(.PINS(PINS)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .drv_nxt (drv_nxt),
        .own_nxt (own_nxt),
        .drv_q   (pin_drv),
        .own_q   (pin_own)
    );
endmodule

// File: rtl/pwm_steer_chk.sv
module pwm_steer_chk #(
    parameter int PINS = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic [2:0]      wave_mode,
    input logic            wave_a,
    input logic            wave_b,
    input logic [PINS-1:0] fixed_drv,
    input logic [PINS-1:0] pin_en,
    input logic [PINS-1:0] pin_steer,
    input logic [PINS-1:0] pin_pol,
    input logic [PINS-1:0] pin_drv,
    input logic [PINS-1:0] pin_own
);
    logic steered_mode;
    assign steered_mode = (wave_mode <= 3'd2);

    // R2: a released pin never drives high
    p_release_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_drv & ~pin_own) == '0);

    // R3: ownership follows the enable one clock later
    p_own_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_en == {PINS{1'b1}}) |=> (pin_own == {PINS{1'b1}}));

    // R4: enabled unsteered pins rest at the inactive level
    p_idle_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        steered_mode |=> (((pin_drv ^ $past(pin_pol)) & $past(pin_en & ~pin_steer)) == '0));

    // R5: single-phase fans wave_a out to every steered pin
    p_fanout_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_mode == 3'd0) |=>
        (((pin_drv ^ $past(pin_pol) ^ {PINS{$past(wave_a)}}) & $past(pin_en & pin_steer)) == '0));

    // R8: non-steered modes carry the fixed per-pin waveform
    p_fixed_map_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !steered_mode |=> (((pin_drv ^ $past(pin_pol) ^ $past(fixed_drv)) & $past(pin_en)) == '0));

    // R1: first cycle after reset is quiet
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (pin_own == '0 && pin_drv == '0));
endmodule

bind pwm_out_steer pwm_steer_chk #(.PINS(PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wave_mode (wave_mode),
    .wave_a    (wave_a),
    .wave_b    (wave_b),
    .fixed_drv (fixed_drv),
    .pin_en    (pin_en),
    .pin_steer (pin_steer),
    .pin_pol   (pin_pol),
    .pin_drv   (pin_drv),
    .pin_own   (pin_own)
);

// File: tb/pwm_out_steer_tb.sv
`timescale 1ns/1ps
module pwm_out_steer_tb;
    localparam int PINS = 6;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [2:0]      wave_mode;
    logic            wave_a, wave_b;
    logic [PINS-1:0] fixed_drv, pin_en, pin_steer, pin_pol;
    logic [PINS-1:0] pin_drv, pin_own;

    int vectors = 0;
    int miscompares = 0;

    always #2.5 clk = ~clk;

    pwm_out_steer #(.PINS(PINS)) u_dut (
        .clk(clk), .rst_n(rst_n), .wave_mode(wave_mode),
        .wave_a(wave_a), .wave_b(wave_b), .fixed_drv(fixed_drv),
        .pin_en(pin_en), .pin_steer(pin_steer), .pin_pol(pin_pol),
        .pin_drv(pin_drv), .pin_own(pin_own)
    );

    function automatic logic [PINS-1:0] model_drv(
        input logic [2:0] m, input logic a, input logic b,
        input logic [PINS-1:0] fx, input logic [PINS-1:0] en,
        input logic [PINS-1:0] st, input logic [PINS-1:0] pol);
        logic [PINS-1:0] r;
        for (int i = 0; i < PINS; i++) begin
            logic lvl;
            if (m <= 3'd2) begin
                lvl = st[i] ? ((m == 3'd1 && (i % 2) == 1) ? b : a) : 1'b0;
            end else begin
                lvl = fx[i];
            end
            r[i] = en[i] ? (lvl ^ pol[i]) : 1'b0;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [PINS-1:0] act,
                         input logic [PINS-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic apply(input string req, input logic [2:0] m, input logic a,
                         input logic b, input logic [PINS-1:0] fx,
                         input logic [PINS-1:0] en, input logic [PINS-1:0] st,
                         input logic [PINS-1:0] pol);
        @(negedge clk);
        wave_mode = m; wave_a = a; wave_b = b; fixed_drv = fx;
        pin_en = en; pin_steer = st; pin_pol = pol;
        @(posedge clk); #1;
        check({req, " drv"}, pin_drv, model_drv(m, a, b, fx, en, st, pol));
        check({req, " own"}, pin_own, en);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0; pin_en = '1; pin_pol = '1; pin_steer = '1; wave_a = 1'b1;
        @(posedge clk); #1;
        check("R1 own", pin_own, '0);
        check("R1 drv", pin_drv, '0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_release;
        apply("R2", 3'd0, 1'b1, 1'b0, '1, 6'b000000, '1, '1);
        apply("R3", 3'd0, 1'b1, 1'b0, '0, 6'b101010, '1, '0);
    endtask

    task automatic t_single;
        apply("R5", 3'd0, 1'b1, 1'b0, '0, '1, 6'b110011, '0);
        apply("R5", 3'd0, 1'b0, 1'b1, '0, '1, 6'b110011, '0);
        apply("R4", 3'd0, 1'b1, 1'b1, '1, '1, 6'b000000, 6'b010101);
    endtask

    task automatic t_comp;
        apply("R6", 3'd1, 1'b1, 1'b0, '0, '1, '1, '0);
        apply("R6", 3'd1, 1'b0, 1'b1, '0, '1, '1, '0);
        apply("R6", 3'd1, 1'b1, 1'b0, '0, '1, 6'b000110, 6'b100000);
    endtask

    task automatic t_sixstep;
        apply("R7", 3'd2, 1'b1, 1'b0, '0, '1, 6'b100001, '0);
        apply("R7", 3'd2, 1'b1, 1'b0, '0, '1, 6'b000110, '0);
    endtask

    task automatic t_fixed;
        for (int m = 3; m < 8; m++)
            apply("R8", 3'(m), 1'b1, 1'b1, 6'b100101, '1, 6'(m * 9), '0);
        apply("R8", 3'd3, 1'b0, 1'b0, 6'b011010, '1, '0, '0);
    endtask

    task automatic t_polarity;
        apply("R9", 3'd0, 1'b1, 1'b0, '0, '1, '1, 6'b001111);
        apply("R9", 3'd4, 1'b0, 1'b0, 6'b110000, '1, '0, '1);
    endtask

    task automatic t_collide;
        apply("R10", 3'd0, 1'b1, 1'b0, '0, '1, '1, '0);
        apply("R2", 3'd0, 1'b1, 1'b0, '0, 6'b011111, '1, 6'b100000);
        apply("R10", 3'd0, 1'b1, 1'b0, 6'b010101, '1, 6'b111000, '0);
        apply("R10", 3'd5, 1'b1, 1'b0, 6'b010101, '1, 6'b000111, '0);
    endtask

    initial begin
        #100000;
        miscompares++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wave_mode = '0; wave_a = 1'b0; wave_b = 1'b0;
        fixed_drv = '0; pin_en = '0; pin_steer = '0; pin_pol = '0;
        repeat (3) @(posedge clk);
        t_reset;
        t_release;
        t_single;
        t_comp;
        t_sixstep;
        t_fixed;
        t_polarity;
        t_collide;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule